// File: doc/BRIEF.md
# Per-Pin Programmable Interrupt Detector for a GPIO Bank

This block watches a bus of general-purpose input pins and raises a single interrupt request whenever one of them shows the event that software has chosen for it. Each pin picks one of five trigger kinds: rising edge, falling edge, either edge, level high or level low. Three per-pin mode bits, spread over three mode words, select the kind. A per-pin enable bit decides whether the pin may record events at all. Recorded events stay in a sticky per-pin pending word. Software clears that word by writing ones to the bits it has serviced.

Pins arrive asynchronously. They pass through a two-stage synchroniser, and a copy of the last synchronised value is kept for edge comparison. Every configuration word and the pending word sit behind a plain register port with one write strobe and one read strobe. Read data appears one clock after the read strobe. The request output is registered and rises one clock after a pending bit meets its enable bit.

Top module: `gpio_irq_bank`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq_out` and `rdata` are 0.
- R2: Registers sit at byte offsets 0x00 (enable), 0x04 (mode A), 0x08 (mode B), 0x0C (mode C) and 0x10 (pending), one bit per pin at the pin's index. `rdata` holds the selected word one clock after `rd_en`. Any other offset reads 0.
- R3: With mode B = 0 and mode C = 0, mode A = 1 records a rising edge and mode A = 0 records a falling edge. The opposite edge records nothing.
- R4: With mode B = 0 and mode C = 1, both edges are recorded, whatever mode A holds.
- R5: With mode B = 1, mode A = 1 records while the pin is high and mode A = 0 records while it is low. A cleared bit sets again on the next clock while that level persists.
- R6: Writing the pending word clears each bit written as 1 and leaves each bit written as 0 unchanged. Without such a write, pending bits never fall.
- R7: A pin whose enable bit is 0 never sets its pending bit.
- R8: `irq_out` is 1 exactly one clock after some pin has both its pending bit and its enable bit set. Clearing the enable bit drops the request without losing the pending bit.
- R9: When a clear and a new event hit the same pending bit at the same clock edge, the bit stays set.
- R10: A pin change sampled at clock edge k sets its pending bit at edge k+2. No spurious edge is recorded after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | PINS | Asynchronous pin inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | PINS | Write data |
| rdata | output | PINS | Read data, valid one clock after `rd_en` |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
The bench uses the default 32-pin width. This lets six low pins carry the five trigger kinds plus one disabled pin, while the upper bits prove that unused pins stay silent and read back 0. A behavioural model, driven by a history queue of sampled pins, predicts `rdata` and `irq_out` on every clock. Directed reads pin down the trigger kinds and the level re-arm after a clear. A write strobe is timed to land on the same edge as a rising event, to check which of the two wins.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam logic [4:0] OFF_EN  = 5'h00;
  localparam logic [4:0] OFF_MA  = 5'h04;
  localparam logic [4:0] OFF_MB  = 5'h08;
  localparam logic [4:0] OFF_MC  = 5'h0C;
  localparam logic [4:0] OFF_PND = 5'h10;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta;

  // Free-running chain: prev tracks cur even during reset, so no edge is seen at release.
  always_ff @(posedge clk) begin
    meta <= pin_in;
    cur  <= meta;
    prev <= cur;
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] en,
  input  logic [W-1:0] mode_a,
  input  logic [W-1:0] mode_b,
  input  logic [W-1:0] mode_c,
  output logic [W-1:0] hit
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic ev;
    always_comb begin
      if (mode_b[i])
        ev = mode_a[i] ? cur[i] : ~cur[i];
      else if (mode_c[i])
        ev = cur[i] ^ prev[i];
      else if (mode_a[i])
        ev = cur[i] & ~prev[i];
      else
        ev = ~cur[i] & prev[i];
    end
    assign hit[i] = ev & en[i];
  end

  // R3 / R4: an edge-mode pin only fires when its synchronised value moved
  a_r3_edge_needs_change: assert property (@(posedge clk) disable iff (rst)
    (hit & ~mode_b & ~(cur ^ prev)) == '0);
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs #(
  parameter int W      = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      hit,
  output logic [W-1:0]      en,
  output logic [W-1:0]      mode_a,
  output logic [W-1:0]      mode_b,
  output logic [W-1:0]      mode_c,
  output logic [W-1:0]      rdata,
  output logic              irq_out
);
  import gpio_irq_pkg::*;

  logic [W-1:0] pnd;
  logic [W-1:0] clr;
  logic [W-1:0] rd_mux;
  logic         wr_pnd;

  assign wr_pnd = wr_en && (addr == ADDR_W'(OFF_PND));
  assign clr    = wr_pnd ? wdata : '0;

  always_comb begin
    unique case (addr)
      ADDR_W'(OFF_EN):  rd_mux = en;
      ADDR_W'(OFF_MA):  rd_mux = mode_a;
      ADDR_W'(OFF_MB):  rd_mux = mode_b;
      ADDR_W'(OFF_MC):  rd_mux = mode_c;
      ADDR_W'(OFF_PND): rd_mux = pnd;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= '0;
      mode_a  <= '0;
      mode_b  <= '0;
      mode_c  <= '0;
      pnd     <= '0;
      rdata   <= '0;
      irq_out <= 1'b0;
    end else begin
      // new events override a same-cycle clear
      pnd     <= (pnd & ~clr) | hit;
      irq_out <= |(pnd & en);
      rdata   <= rd_en ? rd_mux : '0;
      if (wr_en) begin
        if (addr == ADDR_W'(OFF_EN)) en     <= wdata;
        if (addr == ADDR_W'(OFF_MA)) mode_a <= wdata;
        if (addr == ADDR_W'(OFF_MB)) mode_b <= wdata;
        if (addr == ADDR_W'(OFF_MC)) mode_c <= wdata;
      end
    end
  end

  // R6: a pending bit falls only under a pending-word write
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    !wr_pnd |=> ((~pnd & $past(pnd)) == '0));
  // R6 / R9: bits written as 1 and not hit at that edge are clear afterwards
  a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
    wr_pnd |=> ((pnd & $past(wdata) & ~$past(hit)) == '0));
  // R7: the detector never reports a disabled pin
  a_r7_masked: assert property (@(posedge clk) disable iff (rst)
    (hit & ~en) == '0);
  // R8: a request rises only after an enabled pending bit existed
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> $past(|(pnd & en)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int PINS   = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PINS-1:0]   pin_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   wdata,
  output logic [PINS-1:0]   rdata,
  output logic              irq_out
);
  logic [PINS-1:0] cur, prev, hit, en, mode_a, mode_b, mode_c;

  gpio_irq_sync #(.W(PINS)) u_sync (
    .clk(clk), .pin_in(pin_in), .cur(cur), .prev(prev)
  );

  gpio_irq_detect #(.W(PINS)) u_det (
    .clk(clk), .rst(rst), .cur(cur), .prev(prev), .en(en),
    .mode_a(mode_a), .mode_b(mode_b), .mode_c(mode_c), .hit(hit)
  );

  gpio_irq_regs #(.W(PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .hit(hit), .en(en), .mode_a(mode_a), .mode_b(mode_b),
    .mode_c(mode_c), .rdata(rdata), .irq_out(irq_out)
  );
endmodule

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_in = 32'h10;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_out;

  int checks = 0, fails = 0;
  bit started = 0, done = 0;

  gpio_irq_bank u0 (.clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out));

  always #2.5 clk = ~clk;

  // behavioural reference
  logic [31:0] hist[$];
  logic [31:0] m_en, m_a, m_b, m_c, m_p, m_rd;
  logic        m_irq;

  function automatic logic [31:0] m_read(logic [4:0] a);
    case (a)
      5'h00: return m_en;
      5'h04: return m_a;
      5'h08: return m_b;
      5'h0C: return m_c;
      5'h10: return m_p;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] now, old, ev, clrv;
    hist.push_front(pin_in);
    if (hist.size() > 4) void'(hist.pop_back());
    started = 1;
    if (rst) begin
      m_en = 0; m_a = 0; m_b = 0; m_c = 0; m_p = 0; m_rd = 0; m_irq = 0;
    end else begin
      now = (hist.size() >= 4) ? hist[2] : 32'h0;
      old = (hist.size() >= 4) ? hist[3] : 32'h0;
      for (int i = 0; i < 32; i++) begin
        if (m_b[i])      ev[i] = (now[i] == m_a[i]);
        else if (m_c[i]) ev[i] = (now[i] != old[i]);
        else if (m_a[i]) ev[i] = now[i] && !old[i];
        else             ev[i] = !now[i] && old[i];
      end
      ev   = ev & m_en;
      clrv = (wr_en && addr == 5'h10) ? wdata : 32'h0;
      m_rd  = rd_en ? m_read(addr) : 32'h0;
      m_irq = |(m_p & m_en);
      m_p   = (m_p & ~clrv) | ev;
      if (wr_en) begin
        if (addr == 5'h00) m_en = wdata;
        if (addr == 5'h04) m_a  = wdata;
        if (addr == 5'h08) m_b  = wdata;
        if (addr == 5'h0C) m_c  = wdata;
      end
    end
  end

  // continuous comparison away from the active edge (R2, R8, R10)
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (rdata !== m_rd) begin
        fails++;
        $display("FAIL R2/R10 rdata actual %h expected %h at %0t", rdata, m_rd, $time);
      end
      checks++;
      if (irq_out !== m_irq) begin
        fails++;
        $display("FAIL R8/R10 irq_out actual %b expected %b at %0t", irq_out, m_irq, $time);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s read %h actual %h expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (irq_out !== exp) begin
      fails++;
      $display("FAIL %s irq_out actual %b expected %b", tag, irq_out, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic pin(input int idx, input logic v);
    @(negedge clk); pin_in[idx] = v;
    settle();
  endtask

  initial begin
    repeat (6) @(negedge clk);
    rst = 0;
    // R1 reset state
    irq_chk(1'b0, "R1");
    rd_chk(5'h00, 0, "R1"); rd_chk(5'h04, 0, "R1"); rd_chk(5'h08, 0, "R1");
    rd_chk(5'h0C, 0, "R1"); rd_chk(5'h10, 0, "R1");
    // pin0 rise, pin1 fall, pin2 both, pin3 high, pin4 low, pin5 rise disabled
    wr(5'h04, 32'h2D); wr(5'h08, 32'h18); wr(5'h0C, 32'h04);
    wr(5'h10, 32'hFFFF_FFFF); wr(5'h00, 32'h1F);
    rd_chk(5'h04, 32'h2D, "R2"); rd_chk(5'h14, 0, "R2");
    settle();
    rd_chk(5'h10, 0, "R10 no spurious edge");
    // R3 rising
    pin(0, 1); rd_chk(5'h10, 32'h01, "R3 rising"); irq_chk(1'b1, "R8");
    // R6 zeros leave bits, ones clear
    wr(5'h10, 32'h0); rd_chk(5'h10, 32'h01, "R6 zero write");
    // R8 enable masking keeps pending
    wr(5'h00, 32'h1E); repeat (2) @(negedge clk);
    irq_chk(1'b0, "R8 masked"); rd_chk(5'h10, 32'h01, "R8 pending kept");
    wr(5'h00, 32'h1F); repeat (2) @(negedge clk); irq_chk(1'b1, "R8 unmasked");
    wr(5'h10, 32'h01); rd_chk(5'h10, 0, "R6 clear"); repeat (2) @(negedge clk);
    irq_chk(1'b0, "R8 idle");
    // R7 disabled pin
    pin(5, 1); rd_chk(5'h10, 0, "R7 disabled"); irq_chk(1'b0, "R7");
    // R3 falling
    pin(1, 1); rd_chk(5'h10, 0, "R3 wrong edge");
    pin(1, 0); rd_chk(5'h10, 32'h02, "R3 falling");
    wr(5'h10, 32'h02);
    // R4 both edges
    pin(2, 1); rd_chk(5'h10, 32'h04, "R4 rise"); wr(5'h10, 32'h04);
    pin(2, 0); rd_chk(5'h10, 32'h04, "R4 fall"); wr(5'h10, 32'h04);
    rd_chk(5'h10, 0, "R4 cleared");
    // R5 level high and low with re-arm
    pin(3, 1); rd_chk(5'h10, 32'h08, "R5 high");
    wr(5'h10, 32'h08); rd_chk(5'h10, 32'h08, "R5 re-set high");
    pin(3, 0); wr(5'h10, 32'h08); rd_chk(5'h10, 0, "R5 level gone");
    pin(4, 0); rd_chk(5'h10, 32'h10, "R5 low");
    wr(5'h10, 32'h10); rd_chk(5'h10, 32'h10, "R5 re-set low");
    pin(4, 1); wr(5'h10, 32'h10); rd_chk(5'h10, 0, "R5 low gone");
    // R9 clear collides with a rising event on pin0
    pin(0, 0);
    @(negedge clk); pin_in[0] = 1;
    @(negedge clk); @(negedge clk);
    wr_en = 1; addr = 5'h10; wdata = 32'h01;
    @(negedge clk); wr_en = 0;
    rd_chk(5'h10, 32'h01, "R9 event wins");
    wr(5'h10, 32'hFFFF_FFFF); rd_chk(5'h10, 0, "R6 all clear");
    settle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule